// File: doc/BRIEF.md
# Response Transmit Scheduler with NAV Gate

This block launches a short response frame, such as an acknowledgement or a clear-to-send, a fixed interval after a reception or a transmission. Software arms it with a go pulse. Up to three timer-wait enables pick which external interval timers must expire first. Once every selected timer has reported expiry, the block raises a single-cycle transmit start toward the PHY. It then stays busy until the PHY reports that the frame has gone out.

A gate option makes the launch conditional on the virtual carrier sense. When the gate is enabled and the NAV is non-zero in the cycle where the start would be raised, the block drops the frame. It raises no start, returns to idle and records a cancelled status. The interval timers and the NAV counter sit outside the block; only their done and non-zero flags come in. Configuration is captured when go is accepted, so software may reprogram the inputs while a run is in flight.

Top module: `rsp_tx_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes idle: `busy`, `tx_start`, `done_ok` and `done_cancel` are all 0 after that edge.
- R2: If `go` is sampled while idle and `wait_en` is 0, `busy` and `tx_start` are both 1 in the cycle after that edge.
- R3: `wait_en` bit 0 selects post-Rx timer 1, bit 1 selects post-Rx timer 2 and bit 2 selects post-Tx timer 1. Each maps to the `timer_done` bit with the same index. With any bit set, no start is raised until every selected done flag has been sampled high while waiting. The start is raised in the cycle after the edge that samples the last missing flag.
- R4: Selected done flags may arrive as one-cycle pulses in different cycles. Each flag is remembered once seen.
- R5: Done flags of timers that are not selected have no effect. So do done flags that are high while idle or in the cycle of the accepted `go`.
- R6: If `nav_gate_en` was set at `go` and `nav_busy` is 1 in the start cycle, `tx_start` stays 0. The block is idle with `done_cancel` = 1 after the next edge.
- R7: If `nav_gate_en` was clear at `go`, `nav_busy` has no effect and the start is raised.
- R8: After a start, `busy` stays 1 until `phy_done` is sampled. After that edge `busy` = 0 and `done_ok` = 1.
- R9: `tx_start` is high for exactly one cycle per run.
- R10: A sampled `soft_clr` returns the block to idle from any state and clears both status flags. No start is raised in that cycle.
- R11: An accepted `go` clears both status flags. A `go` that arrives while busy is ignored.
- R12: `wait_en` and `nav_gate_en` are captured when `go` is accepted. Later changes do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | Software abort, forces idle |
| go | input | 1 | Starts a new run when idle |
| nav_gate_en | input | 1 | Cancel the frame if NAV is non-zero at launch |
| wait_en | input | 3 | Timer-wait selects (bit0 post-Rx 1, bit1 post-Rx 2, bit2 post-Tx 1) |
| nav_busy | input | 1 | NAV counter is non-zero |
| timer_done | input | 3 | Timer expiry flags, same bit order as wait_en |
| phy_done | input | 1 | PHY has finished the transmission |
| tx_start | output | 1 | One-cycle transmit start pulse |
| busy | output | 1 | A run is in progress |
| done_ok | output | 1 | Last run transmitted |
| done_cancel | output | 1 | Last run was cancelled by the NAV gate |

## Verification
With no wait selected, the start is due one edge after `go`. With waits selected, it is due one edge after the last selected done flag is sampled. A cancel shows on `tx_start` in that same start cycle, and `done_cancel` appears one edge later. `done_ok` appears one edge after `phy_done`, and a soft clear takes effect one edge after it is applied. The directed tasks change inputs on the falling edge and advance one rising edge at a time. Each result is read at the following falling edge, in exactly the cycle the requirement names, and the cycles before it are also checked to show no early start.

// File: rtl/rsp_tx_pkg.sv
// Shared types for the response transmit scheduler.
package rsp_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_FIRE  = 2'd2,
        ST_TXING = 2'd3
    } rsp_state_t;
endpackage

// File: rtl/rsp_tx_wait_latch.sv
// Remembers expiry flags of the selected interval timers during a wait.
// Assumes: sel is stable for a whole run; clr is raised when a run starts.
// all_seen counts a flag that is high in the current cycle as already seen.
module rsp_tx_wait_latch #(
    parameter int NUM_TMR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               capture,
    input  logic [NUM_TMR-1:0] sel,
    input  logic [NUM_TMR-1:0] done,
    output logic               all_seen
);
    logic [NUM_TMR-1:0] seen_q;
    logic [NUM_TMR-1:0] covered;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        // Per-timer sticky flag, set only while waiting and only if selected.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                seen_q[i] <= 1'b0;
            else if (capture && sel[i] && done[i])
                seen_q[i] <= 1'b1;
        end
        // A timer is satisfied if unselected, already seen, or expiring now.
        assign covered[i] = !sel[i] || seen_q[i] || done[i];
    end

    assign all_seen = &covered;
endmodule

// File: rtl/rsp_tx_fsm.sv
// Sequencing core: idle -> (wait) -> fire decision -> transmit -> idle.
// Assumes: all_seen comes from the wait latch driven by cfg_wait/in_wait.
// The NAV gate is evaluated combinationally in the fire cycle.
module rsp_tx_fsm
    import rsp_tx_pkg::*;
#(
    parameter int NUM_TMR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_clr,
    input  logic               go,
    input  logic               nav_gate_en,
    input  logic [NUM_TMR-1:0] wait_en,
    input  logic               nav_busy,
    input  logic               phy_done,
    input  logic               all_seen,
    output logic [NUM_TMR-1:0] cfg_wait,
    output logic               in_wait,
    output logic               clr_seen,
    output logic               tx_start,
    output logic               busy,
    output logic               done_ok,
    output logic               done_cancel
);
    rsp_state_t state_q, state_d;
    logic       cfg_gate_q;
    logic       accept;
    logic       cancel;

    assign accept   = (state_q == ST_IDLE) && go && !soft_clr;
    assign cancel   = (state_q == ST_FIRE) && cfg_gate_q && nav_busy && !soft_clr;
    assign tx_start = (state_q == ST_FIRE) && !(cfg_gate_q && nav_busy) && !soft_clr;
    assign in_wait  = (state_q == ST_WAIT);
    assign clr_seen = accept || soft_clr;
    assign busy     = (state_q != ST_IDLE);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go) state_d = (wait_en == '0) ? ST_FIRE : ST_WAIT;
            ST_WAIT:  if (all_seen) state_d = ST_FIRE;
            ST_FIRE:  state_d = cfg_gate_q && nav_busy ? ST_IDLE : ST_TXING;
            ST_TXING: if (phy_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (soft_clr) state_d = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Configuration captured when a run is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_wait   <= '0;
            cfg_gate_q <= 1'b0;
        end else if (accept) begin
            cfg_wait   <= wait_en;
            cfg_gate_q <= nav_gate_en;
        end
    end

    // Sticky completion status, cleared by a new run or a soft clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr || accept) begin
            done_ok     <= 1'b0;
            done_cancel <= 1'b0;
        end else if (cancel) begin
            done_cancel <= 1'b1;
        end else if (state_q == ST_TXING && phy_done) begin
            done_ok     <= 1'b1;
        end
    end

    assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
    assert_cancel_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_cancel) |-> !$past(tx_start));
    assert_ok_after_phy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_ok) |-> $past(phy_done));
    assert_status_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok && done_cancel));
    assert_soft_clr_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> !busy && !done_ok && !done_cancel);
endmodule

// File: rtl/rsp_tx_sched.sv
// Top: response transmit scheduler with optional NAV cancel at launch.
// Assumes timers and NAV live outside; their flags are synchronous to clk.
module rsp_tx_sched #(
    parameter int NUM_TMR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_clr,
    input  logic               go,
    input  logic               nav_gate_en,
    input  logic [NUM_TMR-1:0] wait_en,
    input  logic               nav_busy,
    input  logic [NUM_TMR-1:0] timer_done,
    input  logic               phy_done,
    output logic               tx_start,
    output logic               busy,
    output logic               done_ok,
    output logic               done_cancel
);
    logic [NUM_TMR-1:0] cfg_wait;
    logic               in_wait;
    logic               clr_seen;
    logic               all_seen;

    rsp_tx_wait_latch #(.NUM_TMR(NUM_TMR)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_seen),
        .capture  (in_wait),
        .sel      (cfg_wait),
        .done     (timer_done),
        .all_seen (all_seen)
    );

    rsp_tx_fsm #(.NUM_TMR(NUM_TMR)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_clr    (soft_clr),
        .go          (go),
        .nav_gate_en (nav_gate_en),
        .wait_en     (wait_en),
        .nav_busy    (nav_busy),
        .phy_done    (phy_done),
        .all_seen    (all_seen),
        .cfg_wait    (cfg_wait),
        .in_wait     (in_wait),
        .clr_seen    (clr_seen),
        .tx_start    (tx_start),
        .busy        (busy),
        .done_ok     (done_ok),
        .done_cancel (done_cancel)
    );

    assert_start_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> busy);
    assert_idle_after_phy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_start && phy_done && !in_wait) |=> !busy);
endmodule

// File: tb/rsp_tx_sched_bench.sv
module rsp_tx_sched_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_clr = 1'b0;
    logic       go = 1'b0;
    logic       nav_gate_en = 1'b0;
    logic [2:0] wait_en = 3'b000;
    logic       nav_busy = 1'b0;
    logic [2:0] timer_done = 3'b000;
    logic       phy_done = 1'b0;
    logic       tx_start, busy, done_ok, done_cancel;
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;

    always #2 clk = ~clk;

    rsp_tx_sched u_rsp_tx_sched (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .go(go),
        .nav_gate_en(nav_gate_en), .wait_en(wait_en), .nav_busy(nav_busy),
        .timer_done(timer_done), .phy_done(phy_done), .tx_start(tx_start),
        .busy(busy), .done_ok(done_ok), .done_cancel(done_cancel)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            errors++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual start/busy/ok/cancel=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {tx_start, busy, done_ok, done_cancel};
    endfunction

    task automatic finish_tx();
        phy_done = 1'b1; tick(); phy_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(); tick();
        chk("R1", outs(), 4'b0000);
        rst_n = 1'b1; tick();
    endtask

    task automatic t_direct();
        wait_en = 3'b000; go = 1'b1; tick(); go = 1'b0;
        chk("R2", outs(), 4'b1100);
        tick();
        chk("R9", outs(), 4'b0100);
        tick();
        chk("R8", outs(), 4'b0100);
        finish_tx();
        chk("R8", outs(), 4'b0010);
    endtask

    task automatic t_wait_multi();
        wait_en = 3'b101; go = 1'b1; tick(); go = 1'b0;
        chk("R3", outs(), 4'b0100);
        timer_done = 3'b001; tick(); timer_done = 3'b000;
        chk("R4", outs(), 4'b0100);
        tick(); tick();
        chk("R4", outs(), 4'b0100);
        timer_done = 3'b100; tick(); timer_done = 3'b000;
        chk("R3", outs(), 4'b1100);
        tick(); finish_tx();
        chk("R8", outs(), 4'b0010);
    endtask

    task automatic t_ignore();
        timer_done = 3'b010; tick();
        chk("R5", outs(), 4'b0010);
        wait_en = 3'b010; go = 1'b1; tick(); go = 1'b0;
        timer_done = 3'b101; tick(); tick();
        chk("R5", outs(), 4'b0100);
        timer_done = 3'b010; tick(); timer_done = 3'b000;
        chk("R5", outs(), 4'b1100);
        tick(); finish_tx();
    endtask

    task automatic t_cancel();
        nav_gate_en = 1'b1; nav_busy = 1'b1; wait_en = 3'b000;
        go = 1'b1; tick(); go = 1'b0;
        chk("R6", outs(), 4'b0100);
        tick();
        chk("R6", outs(), 4'b0001);
        nav_busy = 1'b0;
        go = 1'b1; tick(); go = 1'b0;
        chk("R11", outs(), 4'b1100);
        tick(); finish_tx();
        chk("R6", outs(), 4'b0010);
    endtask

    task automatic t_nogate();
        nav_gate_en = 1'b0; nav_busy = 1'b1; wait_en = 3'b000;
        go = 1'b1; tick(); go = 1'b0;
        chk("R7", outs(), 4'b1100);
        tick(); finish_tx();
        chk("R7", outs(), 4'b0010);
        nav_busy = 1'b0;
    endtask

    task automatic t_softclr();
        wait_en = 3'b001; go = 1'b1; tick(); go = 1'b0;
        soft_clr = 1'b1; tick(); soft_clr = 1'b0;
        chk("R10", outs(), 4'b0000);
        wait_en = 3'b000; go = 1'b1; tick(); go = 1'b0;
        soft_clr = 1'b1;
        #0;
        chk("R10", {tx_start, 3'b000}, 4'b0000);
        tick(); soft_clr = 1'b0;
        chk("R10", outs(), 4'b0000);
    endtask

    task automatic t_config_hold();
        wait_en = 3'b001; nav_gate_en = 1'b0; go = 1'b1; tick(); go = 1'b0;
        wait_en = 3'b011; nav_gate_en = 1'b1; nav_busy = 1'b1;
        go = 1'b1; tick(); go = 1'b0;
        chk("R11", outs(), 4'b0100);
        timer_done = 3'b001; tick(); timer_done = 3'b000;
        chk("R12", outs(), 4'b1100);
        tick(); finish_tx();
        chk("R12", outs(), 4'b0010);
        nav_busy = 1'b0; nav_gate_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_direct();
        t_wait_multi();
        t_ignore();
        t_cancel();
        t_nogate();
        t_softclr();
        t_config_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule